// File: doc/BRIEF.md
# Pipelined Bit-Error Accumulator

This block measures bit errors on a wide datapath. Every clock it takes a received word and the word that should have arrived. It XORs them and adds the number of differing bits to a running error total. Counting the ones in a wide word with a serial chain of additions is too slow at high clock rates, so the count is split across registered stages:

- Each fixed-width slice of the error vector is counted in the first register stage.
- A balanced tree of registered pairwise adders combines the slice counts.
- The tree result enters a carry-save accumulator. This holds the total as two redundant vectors, so the feedback loop carries no carry chain.
- A final stage propagates the carries into a binary total, which saturates at all ones.

The total trails the input by a fixed number of clocks, and that number depends only on the parameters. A valid strobe marks which cycles carry real data. A cycle without it pushes an empty slot down the pipeline, so the latency does not change. A synchronous clear empties the whole pipeline and the accumulator.

`WIDTH` must be a multiple of `SLICE`, and `SLICE` may be at most 64. The default build is 256 data bits, 8-bit slices and a 32-bit total, which gives a latency of 8.

Top module: `bit_err_accum`

## Requirements
- R1: For every word taken with `valid_i` high and `clear_i` and `rst` low, the total grows by the number of 1 bits in `data_i ^ expect_i`.
- R2: A word taken with `valid_i` low adds nothing, whatever its data and expected bits hold.
- R3: Let LATENCY = ceil(log2(WIDTH/SLICE)) + 3. A word sampled at a rising edge first shows in `total_o` after the LATENCY-th rising edge, counting the sampling edge as the first. It never shows earlier.
- R4: A word with no mismatched bits passes through like any other and leaves the total unchanged. Outside clear and reset, the total never decreases.
- R5: The total stops at 2^ACC_W − 1 instead of wrapping, and stays there until a clear or reset.
- R6: When `clear_i` is high at a rising edge, `total_o` reads 0 after that edge. The word presented with the clear and every word still in the pipeline are discarded.
- R7: When `rst` (synchronous, active high) is high at a rising edge, `total_o` reads 0 after that edge. Reset discards in-flight words the same way as R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | The current word carries data |
| data_i | input | WIDTH | Received word |
| expect_i | input | WIDTH | Expected word |
| clear_i | input | 1 | Synchronous request to zero the total and empty the pipeline |
| total_o | output | ACC_W | Saturating error total |

## Verification
The bench builds the block with WIDTH=16, SLICE=4 and ACC_W=10. That gives four slices, a two-level tree and a latency of 5.

With this build every bit position can be swept one at a time in both polarities, and every mismatch count from 0 to 16 can be applied. The 10-bit total saturates after 64 all-error words, so the saturation and hold behaviour is reached within a short run.

Clears and resets are issued while words are still in the pipeline. The bench checks that they are dropped, measuring against a model of the total that is delayed by the latency.

// File: rtl/bea_pkg.sv
package bea_pkg;

  // Count ones in a word of up to 64 bits.
  // Groups of six bits are each reduced to a 3-bit count, then the groups are summed.
  function automatic logic [6:0] ones_in(input logic [63:0] v);
    logic [6:0] acc;
    logic [2:0] grp;
    acc = '0;
    for (int g = 0; g < 11; g++) begin
      grp = 3'd0;
      for (int b = 0; b < 6; b++) begin
        if (g * 6 + b < 64) grp = grp + {2'b00, v[g * 6 + b]};
      end
      acc = acc + {4'b0000, grp};
    end
    return acc;
  endfunction

  // One 3:2 compression step: sum and shifted majority of three vectors.
  function automatic logic [63:0] csa_sum(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [63:0] csa_carry(input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

endpackage

// File: rtl/bea_front.sv
module bea_front #(
  parameter int WIDTH = 256,
  parameter int SLICE = 8,
  localparam int NSLICE = WIDTH / SLICE,
  localparam int CW = $clog2(SLICE + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       valid_i,
  input  logic [WIDTH-1:0]           data_i,
  input  logic [WIDTH-1:0]           expect_i,
  output logic [NSLICE-1:0][CW-1:0]  cnt_o
);

  // Masked error vector: an invalid cycle becomes an all-zero slot.
  logic [WIDTH-1:0] mism_w;
  assign mism_w = valid_i ? (data_i ^ expect_i) : '0;

  logic [NSLICE-1:0][CW-1:0] cnt_w;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign cnt_w[s] = CW'(bea_pkg::ones_in(64'(mism_w[s*SLICE +: SLICE])));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_o <= '0;
    else            cnt_o <= cnt_w;
  end

  // R2: an invalid word leaves only empty slice counts behind
  assert_invalid_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(valid_i)) |-> (cnt_o == '0));

endmodule

// File: rtl/bea_tree.sv
module bea_tree #(
  parameter int N  = 32,
  parameter int TW = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [N-1:0][TW-1:0]  leaves_i,
  output logic [TW-1:0]         root_o
);

  if (N == 1) begin : g_single
    assign root_o = leaves_i[0];
  end else begin : g_multi
    // Heap layout: nodes 0..N-2 are registered adders, N-1..2N-2 are the leaves.
    logic [N-2:0][TW-1:0]   node_q;
    logic [2*N-2:0][TW-1:0] all_w;

    assign all_w  = {leaves_i, node_q};
    assign root_o = node_q[0];

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        node_q <= '0;
      end else begin
        for (int i = 0; i < N - 1; i++) begin
          node_q[i] <= all_w[2*i+1] + all_w[2*i+2];
        end
      end
    end
  end

endmodule

// File: rtl/bea_csa_acc.sv
module bea_csa_acc #(
  parameter int TW    = 9,
  parameter int ACC_W = 32,
  localparam int EW   = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [TW-1:0]    add_i,
  output logic [ACC_W-1:0] total_o
);

  logic [EW-1:0] s_q, c_q, s_nx, c_nx, add_w;
  logic [EW-1:0] resolved_w;
  logic          sat_q, over_w;

  assign add_w = EW'(add_i);
  assign s_nx  = EW'(bea_pkg::csa_sum(64'(s_q), 64'(c_q), 64'(add_w)));
  assign c_nx  = EW'(bea_pkg::csa_carry(64'(s_q), 64'(c_q), 64'(add_w)));

  // Late carry propagation; the guard bit flags overflow
  assign resolved_w = s_q + c_q;
  assign over_w     = sat_q | resolved_w[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      s_q     <= '0;
      c_q     <= '0;
      sat_q   <= 1'b0;
      total_o <= '0;
    end else begin
      s_q     <= s_nx;
      c_q     <= c_nx;
      sat_q   <= over_w;
      total_o <= over_w ? '1 : resolved_w[ACC_W-1:0];
    end
  end

  // R1: the redundant pair always encodes the previous value plus the added count
  assert_csa_tracks_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr)) |-> (resolved_w == $past(resolved_w) + $past(add_w)));

  // R5: once saturated the flag stays until a clear
  assert_sat_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (sat_q && !clr) |=> sat_q);

endmodule

// File: rtl/bit_err_accum.sv
module bit_err_accum #(
  parameter int WIDTH = 256,
  parameter int SLICE = 8,
  parameter int ACC_W = 32,
  localparam int NSLICE  = WIDTH / SLICE,
  localparam int LVLS    = $clog2(NSLICE),
  localparam int NPAD    = 1 << LVLS,
  localparam int CW      = $clog2(SLICE + 1),
  localparam int TW      = $clog2(WIDTH + 1),
  localparam int LATENCY = LVLS + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] expect_i,
  input  logic             clear_i,
  output logic [ACC_W-1:0] total_o
);

  logic [NSLICE-1:0][CW-1:0] slice_cnt_w;
  logic [NPAD-1:0][TW-1:0]   leaves_w;
  logic [TW-1:0]             word_cnt_w;

  bea_front #(.WIDTH(WIDTH), .SLICE(SLICE)) u_front (
    .clk      (clk),
    .rst      (rst),
    .clr      (clear_i),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .expect_i (expect_i),
    .cnt_o    (slice_cnt_w)
  );

  // Pad the slice counts to a power of two with empty leaves
  always_comb begin
    leaves_w = '0;
    for (int j = 0; j < NSLICE; j++) leaves_w[j] = TW'(slice_cnt_w[j]);
  end

  bea_tree #(.N(NPAD), .TW(TW)) u_tree (
    .clk      (clk),
    .rst      (rst),
    .clr      (clear_i),
    .leaves_i (leaves_w),
    .root_o   (word_cnt_w)
  );

  bea_csa_acc #(.TW(TW), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (clear_i),
    .add_i   (word_cnt_w),
    .total_o (total_o)
  );

  // R6: a clear empties the total at once
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (total_o == '0));

  // R4: outside clear and reset the total never falls
  assert_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clear_i)) |-> (total_o >= $past(total_o)));

  // R1: one cycle never adds more than a full word of errors
  assert_step_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clear_i)) |-> ((total_o - $past(total_o)) <= ACC_W'(WIDTH)));

  // R5: a saturated total holds
  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((&total_o) && !clear_i) |=> (&total_o));

endmodule

// File: tb/bit_err_accum_test.sv
module bit_err_accum_test;

  localparam int W    = 16;
  localparam int SL   = 4;
  localparam int AW   = 10;
  localparam int LAT  = $clog2(W / SL) + 3;
  localparam int MAXV = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic [W-1:0]  expect_i = '0;
  logic          clear_i = 1'b0;
  logic [AW-1:0] total_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_clr = 0;
  int ref_tot  = 0;
  int hist [64];
  bit done = 1'b0;

  bit_err_accum #(.WIDTH(W), .SLICE(SL), .ACC_W(AW)) uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .data_i(data_i),
    .expect_i(expect_i), .clear_i(clear_i), .total_o(total_o)
  );

  always #5 clk = ~clk;

  // Kernighan count: clear the lowest set bit until nothing is left
  function automatic int kcount(input logic [W-1:0] v);
    int n = 0;
    logic [W-1:0] t = v;
    while (t != '0) begin
      t = t & (t - 1'b1);
      n++;
    end
    return n;
  endfunction

  task automatic report(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: total_o=%0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Drive one word at a falling edge, advance one clock, then compare against the delayed model
  task automatic step(input logic [W-1:0] d, input logic [W-1:0] e, input logic v,
                      input logic c, input logic r, input string tag);
    int expv;
    data_i = d; expect_i = e; valid_i = v; clear_i = c; rst = r;
    if (c || r) begin
      ref_tot  = 0;
      last_clr = cyc;
    end else if (v) begin
      ref_tot = ref_tot + kcount(d ^ e);
      if (ref_tot > MAXV) ref_tot = MAXV;
    end
    hist[cyc % 64] = ref_tot;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc - LAT < 0 || cyc - LAT < last_clr) expv = 0;
    else expv = hist[(cyc - LAT) % 64];
    if (total_o !== AW'(expv)) begin
      checks++;
      fails++;
      $display("FAIL %s: total_o=%0d expected %0d (cycle %0d)", tag, total_o, expv, cyc);
    end else begin
      checks++;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step('0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    report("R7", int'(total_o), 0);
    rst = 1'b0;

    // R1: walking single mismatch, both polarities
    for (int i = 0; i < W; i++) begin
      step(W'(1) << i, '0, 1'b1, 1'b0, 1'b0, "R1");
      step('0, W'(1) << i, 1'b1, 1'b0, 1'b0, "R1");
    end
    // R1: every mismatch count 0..W at shifting positions over varied data
    for (int k = 0; k <= W; k++) begin
      logic [W-1:0] m, d;
      m = W'((17'(1) << k) - 17'(1));
      m = (m << (k % W)) | (m >> (W - (k % W)));
      d = W'($urandom);
      step(d, d ^ m, 1'b1, 1'b0, 1'b0, "R1");
    end
    idle(LAT, "R1");

    // R2: invalid words full of errors add nothing
    for (int i = 0; i < 8; i++) step(W'($urandom), ~W'($urandom), 1'b0, 1'b0, 1'b0, "R2");
    step('1, '0, 1'b0, 1'b0, 1'b0, "R2");
    idle(LAT, "R2");

    // R4: error-free words leave the total unchanged
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      step(d, d, 1'b1, 1'b0, 1'b0, "R4");
    end
    idle(LAT, "R4");

    // R3: exact latency of one word after a clear
    step('0, '0, 1'b0, 1'b1, 1'b0, "R6");
    step(16'h0F01, '0, 1'b1, 1'b0, 1'b0, "R3");
    idle(LAT + 2, "R3");

    // Mixed traffic with random valid
    for (int i = 0; i < 40; i++) step(W'($urandom), W'($urandom), 1'($urandom), 1'b0, 1'b0, "R1");
    idle(LAT, "R1");

    // R6: clear with words in flight and a valid word on the clear cycle
    for (int i = 0; i < 3; i++) step('1, '0, 1'b1, 1'b0, 1'b0, "R6");
    step('1, '0, 1'b1, 1'b1, 1'b0, "R6");
    idle(LAT + 1, "R6");

    // R5: saturate, keep feeding, then clear
    for (int i = 0; i < 75; i++) step('1, '0, 1'b1, 1'b0, 1'b0, "R5");
    idle(LAT, "R5");
    report("R5", int'(total_o), MAXV);
    step('0, '0, 1'b0, 1'b1, 1'b0, "R5");
    idle(LAT, "R5");

    // R7: reset in the middle of traffic
    for (int i = 0; i < 3; i++) step(16'h00FF, '0, 1'b1, 1'b0, 1'b0, "R7");
    step(16'h00FF, '0, 1'b1, 1'b0, 1'b1, "R7");
    idle(LAT + 1, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: total_o=%0d expected run end (cycle %0d)", total_o, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule